// File: doc/BRIEF.md
# Interrupt Request Acknowledge Sequencer

This block is the interrupt front end of a small processor core. It watches an asynchronous non-maskable request and a level-sensitive maskable request. At each instruction boundary it decides whether the core should take an interrupt. A non-maskable event produces a one-cycle take pulse with the fixed vector type 2.

A maskable request that arrives while the enable flag is set starts a handshake toward an external interrupt controller. The handshake drives two active-low acknowledge pulses and holds an active-low lock line low across the first of them. It captures the vector byte that the controller drives at the end of the second pulse, and then hands that byte to the core. The block also tells the core when to clear its interrupt-enable flag.

The core asserts `insn_end_i` for one clock in the last clock of every instruction. It holds `str_busy_i` high while a repeated string instruction still has elements left to process. While `busy_o` is high the core stalls and waits for `take_o`.

Top module: `irq_ack_seq`

## Requirements
- R1: While reset is asserted and after it is released: `inta_no`=1, `lock_no`=1, `take_o`=0, `clr_ie_o`=0, `busy_o`=0 and `vec_o`=0.
- R2: `nmi_i` passes through a two-flop synchroniser. A request is recognised only after the synchronised level has been seen high on at least 2 consecutive clocks. A level that is sampled high on one clock edge only is dropped.
- R3: A recognised non-maskable request is latched on its rising edge and serviced exactly once. Holding `nmi_i` high across several boundaries does not produce a second service.
- R4: Interrupts are accepted only on a clock where `insn_end_i`=1 and `busy_o`=0. A non-maskable acceptance gives `take_o`=1 with `vec_o`=8'h02 in the next clock, for exactly one clock.
- R5: If a latched non-maskable request and an enabled maskable request are both present at a boundary, the non-maskable one is serviced. The maskable one is serviced at a later boundary if `intr_i` is still high there.
- R6: A boundary with `str_busy_i`=1 does not accept a latched non-maskable request; the request stays latched for the first boundary with `str_busy_i`=0. A maskable request may still be accepted at such a boundary.
- R7: A maskable request is accepted only if `intr_i`=1 and `ie_i`=1 in the boundary clock. With `ie_i`=0, or with `intr_i` low in that clock, no acknowledge takes place.
- R8: `clr_ie_o` is a one-clock pulse in the first clock of the first acknowledge pulse. It is never asserted for a non-maskable service.
- R9: After a maskable acceptance, `inta_no` is low for 2 clocks. It is then high for 2 idle clocks, and then low for 2 more clocks.
- R10: `lock_no` is low from the first clock of the first acknowledge pulse through the last idle clock. It returns high in the clock in which the second acknowledge pulse begins.
- R11: `vec_i` is sampled in the last clock of the second acknowledge pulse. The next clock shows `take_o`=1 with that byte on `vec_o`, and `vec_o` then holds it.
- R12: `insn_end_i` is ignored while `busy_o`=1, so a boundary seen during a sequence starts no second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| nmi_i | input | 1 | Non-maskable request, asynchronous |
| intr_i | input | 1 | Maskable request, level |
| ie_i | input | 1 | Interrupt-enable flag from the core |
| insn_end_i | input | 1 | High in the last clock of each instruction |
| str_busy_i | input | 1 | Repeated string operation not yet complete |
| vec_i | input | 8 | Vector byte from the external controller |
| inta_no | output | 1 | Active-low acknowledge |
| lock_no | output | 1 | Active-low bus lock |
| take_o | output | 1 | One-clock pulse: take the vector on `vec_o` |
| vec_o | output | 8 | Vector type to take |
| clr_ie_o | output | 1 | Pulse telling the core to clear its enable flag |
| busy_o | output | 1 | Service in progress, core stalls |

## Verification
The bench sends a single-clock non-maskable glitch, which a design with too short a qualifier would service. It holds `nmi_i` high across two boundaries, which catches level-triggered servicing that fires twice. It sets up a boundary where both requests are pending, which shows whether the arbiter picks the wrong request or loses the maskable one. It puts a boundary inside a string operation, where a design without the hold-off would take the vector early. It also pulses `insn_end_i` in the middle of a handshake, which a design that restarts would answer with extra acknowledge pulses. A reference timeline compares every output on every clock, so an acknowledge pulse of the wrong length, a lock released one clock late, or a vector sampled one clock off shows up as a mismatch at the exact cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ACK1,
    S_GAP,
    S_ACK2,
    S_TAKE
  } seq_st_e;

  localparam logic [7:0] NMI_VEC = 8'h02;
endpackage

// File: rtl/nmi_qual.sv
module nmi_qual #(
  parameter int SYNC   = 2,
  parameter int MIN_HI = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nmi_i,
  input  logic clr_i,
  output logic pend_o
);
  localparam int HW = $clog2(MIN_HI + 1);

  logic [SYNC-1:0] sync_q;
  logic [HW-1:0]   hcnt_q;
  logic            lvl;
  logic            ev;
  logic            pend_q;

  for (genvar g = 0; g < SYNC; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= nmi_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
    end
  end

  assign lvl = sync_q[SYNC-1];
  // fires once, on the clock the level completes its minimum width
  assign ev  = lvl && (hcnt_q == HW'(MIN_HI - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (!lvl)                         hcnt_q <= '0;
      else if (hcnt_q != HW'(MIN_HI))   hcnt_q <= hcnt_q + 1'b1;
      pend_q <= ev | (pend_q & ~clr_i);
    end
  end

  assign pend_o = pend_q;

  p_min_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> ($past(lvl) && $past(lvl, 2)));
endmodule

// File: rtl/irq_arb.sv
module irq_arb (
  input  logic idle_i,
  input  logic bnd_i,
  input  logic nmi_pend_i,
  input  logic str_busy_i,
  input  logic intr_i,
  input  logic ie_i,
  output logic take_nmi_o,
  output logic take_intr_o
);
  logic at_bnd;
  logic nmi_ok;

  always_comb begin
    at_bnd      = idle_i & bnd_i;
    nmi_ok      = nmi_pend_i & ~str_busy_i;
    take_nmi_o  = at_bnd & nmi_ok;
    take_intr_o = at_bnd & ~nmi_ok & intr_i & ie_i;
  end
endmodule

// File: rtl/ack_seq.sv
module ack_seq
  import irq_seq_pkg::*;
#(
  parameter int ACK_LEN = 2,
  parameter int GAP_LEN = 2,
  parameter int VW      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_nmi_i,
  input  logic          start_intr_i,
  input  logic [VW-1:0] vec_i,
  output logic          inta_no,
  output logic          lock_no,
  output logic          take_o,
  output logic          clr_ie_o,
  output logic [VW-1:0] vec_o,
  output logic          busy_o
);
  localparam int MAXL = (ACK_LEN > GAP_LEN) ? ACK_LEN : GAP_LEN;
  localparam int CW   = $clog2(MAXL + 1);

  seq_st_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [VW-1:0] vec_q;
  logic          ack_last, gap_last;

  assign ack_last = (cnt_q == CW'(ACK_LEN - 1));
  assign gap_last = (cnt_q == CW'(GAP_LEN - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    unique case (st_q)
      S_IDLE: begin
        cnt_d = '0;
        if (start_nmi_i)       st_d = S_TAKE;
        else if (start_intr_i) st_d = S_ACK1;
      end
      S_ACK1: if (ack_last) begin st_d = S_GAP;  cnt_d = '0; end
      S_GAP:  if (gap_last) begin st_d = S_ACK2; cnt_d = '0; end
      S_ACK2: if (ack_last) begin st_d = S_TAKE; cnt_d = '0; end
      S_TAKE: begin st_d = S_IDLE; cnt_d = '0; end
      default: begin st_d = S_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      vec_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (st_q == S_IDLE && start_nmi_i)  vec_q <= VW'(NMI_VEC);
      else if (st_q == S_ACK2 && ack_last) vec_q <= vec_i;
    end
  end

  assign inta_no  = ~(st_q == S_ACK1 || st_q == S_ACK2);
  assign lock_no  = ~(st_q == S_ACK1 || st_q == S_GAP);
  assign take_o   = (st_q == S_TAKE);
  assign clr_ie_o = (st_q == S_ACK1) && (cnt_q == '0);
  assign vec_o    = vec_q;
  assign busy_o   = (st_q != S_IDLE);

  p_ack_width_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inta_no && $past(inta_no)) |=> !inta_no);
  p_lock_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_no) |-> !inta_no);
  p_take_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (!take_o && !busy_o));
  p_clr_in_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ie_o |-> (!inta_no && !lock_no && !take_o));
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_seq_pkg::*;
#(
  parameter int SYNC    = 2,
  parameter int NMI_MIN = 2,
  parameter int ACK_LEN = 2,
  parameter int GAP_LEN = 2,
  parameter int VW      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          nmi_i,
  input  logic          intr_i,
  input  logic          ie_i,
  input  logic          insn_end_i,
  input  logic          str_busy_i,
  input  logic [VW-1:0] vec_i,
  output logic          inta_no,
  output logic          lock_no,
  output logic          take_o,
  output logic [VW-1:0] vec_o,
  output logic          clr_ie_o,
  output logic          busy_o
);
  logic nmi_pend;
  logic take_nmi, take_intr;

  nmi_qual #(.SYNC(SYNC), .MIN_HI(NMI_MIN)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nmi_i  (nmi_i),
    .clr_i  (take_nmi),
    .pend_o (nmi_pend)
  );

  irq_arb u_arb (
    .idle_i      (~busy_o),
    .bnd_i       (insn_end_i),
    .nmi_pend_i  (nmi_pend),
    .str_busy_i  (str_busy_i),
    .intr_i      (intr_i),
    .ie_i        (ie_i),
    .take_nmi_o  (take_nmi),
    .take_intr_o (take_intr)
  );

  ack_seq #(.ACK_LEN(ACK_LEN), .GAP_LEN(GAP_LEN), .VW(VW)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_nmi_i  (take_nmi),
    .start_intr_i (take_intr),
    .vec_i        (vec_i),
    .inta_no      (inta_no),
    .lock_no      (lock_no),
    .take_o       (take_o),
    .clr_ie_o     (clr_ie_o),
    .vec_o        (vec_o),
    .busy_o       (busy_o)
  );

  p_ie_mask_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_end_i && !busy_o && !ie_i) |=> (inta_no && !clr_ie_o));
  p_str_defer_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_end_i && !busy_o && str_busy_i) |=> !take_o);
  p_no_restart_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !clr_ie_o);
  p_nmi_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_end_i && !busy_o && nmi_pend && !str_busy_i) |=> (take_o && inta_no));
endmodule

// File: tb/sim_irq_ack_seq.sv
`timescale 1ns/1ps
module sim_irq_ack_seq;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic nmi = 1'b0, intr = 1'b0, ie = 1'b0, iend = 1'b0, sbusy = 1'b0;
  logic [7:0] vin = 8'h00;
  logic inta_n, lock_n, take, clr_ie, busy;
  logic [7:0] vout;

  always #2 clk = ~clk;

  irq_ack_seq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .nmi_i(nmi), .intr_i(intr), .ie_i(ie),
    .insn_end_i(iend), .str_busy_i(sbusy), .vec_i(vin),
    .inta_no(inta_n), .lock_no(lock_n), .take_o(take), .vec_o(vout),
    .clr_ie_o(clr_ie), .busy_o(busy)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  int n_take = 0, n_nmi = 0, last_vec = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference timeline: t=1..2 first pulse, 3..4 gap, 5..6 second pulse, 7 take
  int m_s1, m_s2, m_run, m_pend, m_t, m_nt, m_vec, m_ev, m_an, m_ai;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = 0; m_s2 = 0; m_run = 0; m_pend = 0; m_t = 0; m_nt = 0; m_vec = 0;
    end else begin
      m_ev = (m_s2 != 0 && m_run == 1) ? 1 : 0;
      m_an = 0; m_ai = 0;
      if (m_t == 0 && m_nt == 0 && iend) begin
        if (m_pend != 0 && !sbusy) m_an = 1;
        else if (intr && ie)       m_ai = 1;
      end
      m_nt = 0;
      if (m_t == 6) m_vec = vin;
      if (m_t == 7) m_t = 0;
      else if (m_t > 0) m_t = m_t + 1;
      if (m_an != 0) begin m_nt = 1; m_vec = 2; end
      if (m_ai != 0) m_t = 1;
      m_pend = (m_ev != 0 || (m_pend != 0 && m_an == 0)) ? 1 : 0;
      m_run = (m_s2 != 0) ? ((m_run < 2) ? m_run + 1 : 2) : 0;
      m_s2 = m_s1;
      m_s1 = nmi;
    end
  end

  always @(negedge clk) begin
    if (!rst_ni) begin
      chk("R1 inta_no in reset", inta_n, 1);
      chk("R1 lock_no in reset", lock_n, 1);
      chk("R1 take_o in reset", take, 0);
      chk("R1 busy_o in reset", busy, 0);
    end else begin
      chk("R9 inta_no", inta_n, (m_t==1||m_t==2||m_t==5||m_t==6) ? 0 : 1);
      chk("R10 lock_no", lock_n, (m_t>=1 && m_t<=4) ? 0 : 1);
      chk("R4/R11 take_o", take, (m_t==7 || m_nt!=0) ? 1 : 0);
      chk("R8 clr_ie_o", clr_ie, (m_t==1) ? 1 : 0);
      chk("R12 busy_o", busy, (m_t!=0 || m_nt!=0) ? 1 : 0);
      chk("R11 vec_o", vout, m_vec);
      if (take) begin
        n_take++;
        last_vec = vout;
        if (vout == 8'h02) n_nmi++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bnd();
    @(negedge clk) iend = 1'b1;
    @(negedge clk) iend = 1'b0;
  endtask

  int snap;
  initial begin
    tick(3);
    chk("R1 vec_o in reset", vout, 0);
    chk("R1 clr_ie_o in reset", clr_ie, 0);
    @(negedge clk) rst_ni = 1'b1;
    tick(3);
    chk("R1 idle after reset", busy, 0);

    // R7/R11: enabled maskable request, full handshake
    intr = 1; ie = 1; vin = 8'h4a;
    bnd();
    tick(12);
    intr = 0;
    chk("R11 one maskable service", n_take, 1);
    chk("R11 captured vector", last_vec, 8'h4a);

    // R7: enable clear blocks the maskable request
    ie = 0; intr = 1;
    snap = n_take;
    bnd(); tick(10);
    chk("R7 masked request ignored", n_take, snap);
    // R4: no boundary, no acceptance
    ie = 1;
    tick(10);
    chk("R4 no boundary no service", n_take, snap);
    intr = 0;
    // R7: intr low in the boundary clock
    bnd(); tick(10);
    chk("R7 intr low at boundary ignored", n_take, snap);

    // R2: single-clock glitch dropped
    @(negedge clk) nmi = 1;
    @(negedge clk) nmi = 0;
    tick(6); bnd(); tick(4);
    chk("R2 glitch not serviced", n_nmi, 0);

    // R2/R4: two-clock pulse serviced with vector 2
    @(negedge clk) nmi = 1;
    tick(2); nmi = 0;
    tick(6);
    chk("R4 pending waits for boundary", n_nmi, 0);
    bnd(); tick(4);
    chk("R2 qualified pulse serviced", n_nmi, 1);
    chk("R4 fixed vector", last_vec, 2);

    // R3: held level serviced once
    @(negedge clk) nmi = 1;
    tick(8); bnd(); tick(4); bnd(); tick(4); bnd(); tick(4);
    nmi = 0;
    chk("R3 held request serviced once", n_nmi, 2);
    tick(4);

    // R5: both pending, non-maskable wins, maskable later
    vin = 8'h31;
    @(negedge clk) nmi = 1;
    tick(3); nmi = 0; tick(4);
    intr = 1; ie = 1;
    snap = n_take;
    bnd(); tick(3);
    chk("R5 non-maskable first", n_take, snap + 1);
    chk("R5 non-maskable vector", last_vec, 2);
    bnd(); tick(12);
    intr = 0;
    chk("R5 maskable serviced later", last_vec, 8'h31);
    chk("R5 two services", n_take, snap + 2);

    // R6: string operation defers the non-maskable request
    @(negedge clk) nmi = 1;
    tick(3); nmi = 0; tick(4);
    sbusy = 1;
    snap = n_nmi;
    bnd(); tick(3); bnd(); tick(3);
    chk("R6 deferred during string", n_nmi, snap);
    sbusy = 0;
    bnd(); tick(3);
    chk("R6 taken after string", n_nmi, snap + 1);

    // R6: maskable still accepted while string op defers non-maskable
    @(negedge clk) nmi = 1;
    tick(3); nmi = 0; tick(4);
    sbusy = 1; intr = 1; vin = 8'h77;
    bnd(); tick(12);
    intr = 0;
    chk("R6 maskable during string", last_vec, 8'h77);
    sbusy = 0;
    bnd(); tick(3);
    chk("R6 non-maskable kept latched", last_vec, 2);

    // R12: boundaries during a handshake are ignored
    intr = 1; vin = 8'h5c;
    snap = n_take;
    bnd(); bnd(); bnd(); bnd(); intr = 0;
    tick(10);
    chk("R12 single sequence", n_take, snap + 1);
    chk("R12 vector", last_vec, 8'h5c);

    tick(5);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule